// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames, arriving one byte at a time, into a ring of fixed-size memory buffers. Each buffer is described by a pair of 32-bit words in memory. The first word holds the buffer address, a hand-back flag and an end-of-ring flag. The second word holds status. The block walks the ring from a programmable base address. Before it fills a buffer it reads that buffer's first word. Once the buffer is filled, it writes the status word and then returns the buffer to software by setting the hand-back flag.

A frame longer than one buffer is spread across consecutive descriptors. Every descriptor a frame touches gets its own status word. The first and last buffer of the frame are marked, and the last one also carries the total byte count. If the block meets a descriptor that software has not yet released, it discards the remainder of the frame and raises a sticky "no buffer" flag.

A second sticky flag reports each completely stored frame. Software clears either flag by pulsing its clear bit.

Top module: `rxr_desc_writer`

## Requirements
- R1: Descriptor n sits at ring base + 8·n. Word 0 bit 0 is the hand-back flag and bit 1 is the end-of-ring flag. After a descriptor with bit 1 set, the next descriptor used is the one at the ring base.
- R2: The buffer address is word 0 with bits [1:0] forced to zero. Frame bytes are written as 32-bit words in little-endian lane order, with the first byte of a word in bits [7:0]. A final partial word has its unused lanes written as zero.
- R3: The status word carries bit 14 = first buffer of the frame and bit 15 = last buffer of the frame. Bits [11:0] hold the frame byte count in the last buffer and zero in every other buffer.
- R4: The match flags in_match[6], [5] and [4] (broadcast, multicast, unicast) and in_match[3:0] (four specific addresses) are captured with the frame-start byte. They are written to status bits 31, 30 and 29 and to bits 26..23 of every descriptor of that frame. All other status bits are zero.
- R5: For each buffer the writes come in this order: the data words, then the status word at descriptor + 4, then word 0 with bit 0 set and the address and end-of-ring bits unchanged.
- R6: A frame of more than BUF_BYTES bytes continues in the following descriptors. A frame of exactly BUF_BYTES bytes uses a single descriptor.
- R7: If a fetched descriptor already has bit 0 set, the block consumes and discards the rest of the frame, sets buf_unavail and writes nothing more for that frame. The ring position stays on that descriptor.
- R8: frame_rcvd is set one cycle after the hand-back write of a frame's last buffer. A pulse on flag_clr[0] clears it and a pulse on flag_clr[1] clears buf_unavail. Both flags are zero after reset.
- R9: While rx_en is low and no frame is in progress, the ring position returns to ring_base, incoming bytes are accepted and discarded, and memory is not accessed.
- R10: While enabled and idle, bytes that do not carry in_sof are accepted and discarded without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Byte address of descriptor 0 |
| in_valid | input | 1 | Byte present on in_data |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_match | input | 7 | Destination match flags, held for the frame |
| in_ready | output | 1 | Byte accepted on this edge when in_valid is high |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| flag_clr | input | 2 | Write-one clear: bit 0 frame_rcvd, bit 1 buf_unavail |
| frame_rcvd | output | 1 | Sticky: a complete frame was stored |
| buf_unavail | output | 1 | Sticky: a frame was cut short for lack of a buffer |

## Verification
The bench builds the block with BUF_BYTES = 16 over a ring of four descriptors. With these values a 37-byte frame crosses two buffer boundaries and the end of the ring, and a 60-byte frame uses every descriptor in the ring at once. Exact-fit and single-byte frames, a frame cut short partway through by an unreleased descriptor, and the rewind on disable all stay within a few hundred cycles. A behavioural model predicts every memory write, with its address and data, and compares them in order as they appear.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_RWAIT,
        S_FILL,
        S_STAT,
        S_OWN,
        S_DROP
    } rxr_state_e;

    typedef struct packed {
        logic       bcast;
        logic       mcast;
        logic       ucast;
        logic [3:0] sa;
    } rxr_match_t;

    localparam int LEN_W = 12;

    function automatic logic [31:0] rxr_status_word(
        input rxr_match_t       m,
        input logic             first,
        input logic             last,
        input logic [LEN_W-1:0] len
    );
        logic [31:0] w;
        w        = '0;
        w[31]    = m.bcast;
        w[30]    = m.mcast;
        w[29]    = m.ucast;
        w[26:23] = m.sa;
        w[15]    = last;
        w[14]    = first;
        w[11:0]  = last ? len : '0;
        return w;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int STRIDE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_base,
    input  logic        advance,
    input  logic        wrap,
    input  logic [31:0] base,
    output logic [31:0] ptr
);
    logic [31:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_base) begin
            ptr_d = base;
        end else if (advance) begin
            ptr_d = wrap ? base : ptr_q + 32'(STRIDE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 flush,
    input  logic [1:0]           lane,
    input  logic [7:0]           data,
    output logic [8*LANES-1:0]   word
);
    logic [8*LANES-1:0] acc_d, acc_q, merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = (lane == 2'(g)) ? data : acc_q[8*g +: 8];
    end

    always_comb begin
        acc_d = acc_q;
        if (flush)     acc_d = '0;
        else if (take) acc_d = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign word = merged;
endmodule

// File: rtl/rxr_flags.sv
module rxr_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    logic [N-1:0] q_d, q_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_comb begin
            q_d[g] = q_q[g];
            if (clr[g]) q_d[g] = 1'b0;
            if (set[g]) q_d[g] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/rxr_desc_writer.sv
module rxr_desc_writer
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic [31:0] ring_base,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [6:0]  in_match,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic [1:0]  flag_clr,
    output logic        frame_rcvd,
    output logic        buf_unavail
);
    localparam int CNT_W    = $clog2(BUF_BYTES + 1);
    localparam int DESC_STR = 8;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BUF_BYTES - 1);

    typedef struct packed {
        rxr_state_e       state;
        logic [31:0]      buf_addr;
        logic             wrap;
        logic [CNT_W-1:0] buf_cnt;
        logic [LEN_W-1:0] frm_len;
        logic             first;
        logic             last;
        rxr_match_t       match;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic        load_base, advance, take, flush;
    logic [31:0] ptr, packed_word, data_off;
    logic [1:0]  flag_set, flag_q;

    rxr_ring_ptr #(.STRIDE(DESC_STR)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (load_base),
        .advance   (advance),
        .wrap      (ctl_q.wrap),
        .base      (ring_base),
        .ptr       (ptr)
    );

    rxr_packer #(.LANES(4)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .flush (flush),
        .lane  (ctl_q.buf_cnt[1:0]),
        .data  (in_data),
        .word  (packed_word)
    );

    rxr_flags #(.N(2)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .q     (flag_q)
    );

    assign frame_rcvd  = flag_q[0];
    assign buf_unavail = flag_q[1];

    always_comb begin
        data_off      = 32'(ctl_q.buf_cnt);
        data_off[1:0] = 2'b00;
    end

    always_comb begin
        ctl_d     = ctl_q;
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        take      = 1'b0;
        flush     = 1'b0;
        load_base = 1'b0;
        advance   = 1'b0;
        flag_set  = '0;

        unique case (ctl_q.state)
            S_IDLE: begin
                if (!rx_en) begin
                    in_ready  = 1'b1;
                    load_base = 1'b1;
                end else if (in_valid && !in_sof) begin
                    in_ready = 1'b1;
                end else if (in_valid) begin
                    ctl_d.state   = S_FETCH;
                    ctl_d.match   = rxr_match_t'(in_match);
                    ctl_d.first   = 1'b1;
                    ctl_d.frm_len = '0;
                end
            end

            S_FETCH: begin
                mem_req     = 1'b1;
                mem_addr    = ptr;
                ctl_d.state = S_RWAIT;
            end

            S_RWAIT: begin
                if (mem_rdata[0]) begin
                    flag_set[1] = 1'b1;
                    ctl_d.state = S_DROP;
                end else begin
                    ctl_d.buf_addr = {mem_rdata[31:2], 2'b00};
                    ctl_d.wrap     = mem_rdata[1];
                    ctl_d.buf_cnt  = '0;
                    ctl_d.state    = S_FILL;
                end
            end

            S_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    take          = 1'b1;
                    ctl_d.buf_cnt = ctl_q.buf_cnt + 1'b1;
                    ctl_d.frm_len = ctl_q.frm_len + 1'b1;
                    if (ctl_q.buf_cnt[1:0] == 2'd3 || in_eof) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = ctl_q.buf_addr + data_off;
                        mem_wdata = packed_word;
                        flush     = 1'b1;
                    end
                    if (in_eof) begin
                        ctl_d.last  = 1'b1;
                        ctl_d.state = S_STAT;
                    end else if (ctl_q.buf_cnt == LAST_IDX) begin
                        ctl_d.last  = 1'b0;
                        ctl_d.state = S_STAT;
                    end
                end
            end

            S_STAT: begin
                mem_req     = 1'b1;
                mem_we      = 1'b1;
                mem_addr    = ptr + 32'd4;
                mem_wdata   = rxr_status_word(ctl_q.match, ctl_q.first,
                                              ctl_q.last, ctl_q.frm_len);
                ctl_d.state = S_OWN;
            end

            S_OWN: begin
                mem_req     = 1'b1;
                mem_we      = 1'b1;
                mem_addr    = ptr;
                mem_wdata   = {ctl_q.buf_addr[31:2], ctl_q.wrap, 1'b1};
                advance     = 1'b1;
                ctl_d.first = 1'b0;
                if (ctl_q.last) begin
                    flag_set[0] = 1'b1;
                    ctl_d.state = S_IDLE;
                end else begin
                    ctl_d.state = S_FETCH;
                end
            end

            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_eof) ctl_d.state = S_IDLE;
            end

            default: ctl_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/rxr_checks.sv
module rxr_checks
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 128
) (
    input logic                             clk,
    input logic                             rst_n,
    input rxr_state_e                       st,
    input logic [$clog2(BUF_BYTES+1)-1:0]   cnt,
    input logic                             rx_en,
    input logic [31:0]                      ring_base,
    input logic [31:0]                      ptr,
    input logic                             mem_req,
    input logic                             mem_we,
    input logic                             frame_rcvd,
    input logic                             buf_unavail
);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !mem_req);

    assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DROP) |-> !mem_req);

    assert_bna_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_unavail) |-> ($past(st) == S_RWAIT));

    assert_own_after_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OWN) |-> (mem_we && $past(st) == S_STAT));

    assert_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !rx_en) |=> (ptr == $past(ring_base)));

    assert_buf_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ($clog2(BUF_BYTES+1))'(BUF_BYTES));

    assert_done_after_own_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_rcvd) |-> ($past(st) == S_OWN));
endmodule

bind rxr_desc_writer rxr_checks #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (ctl_q.state),
    .cnt         (ctl_q.buf_cnt),
    .rx_en       (rx_en),
    .ring_base   (ring_base),
    .ptr         (ptr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .frame_rcvd  (frame_rcvd),
    .buf_unavail (buf_unavail)
);

// File: tb/tb_rxr_desc_writer.sv
`timescale 1ns/1ps
module tb_rxr_desc_writer;
    localparam int BUF   = 16;
    localparam int NDESC = 4;
    localparam logic [31:0] DBASE = 32'h100;
    localparam logic [31:0] BBASE = 32'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [31:0] ring_base = DBASE;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sof = 1'b0, in_eof = 1'b0;
    logic [6:0]  in_match = '0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  flag_clr = '0;
    logic        frame_rcvd, buf_unavail;

    always #2.5 clk = ~clk;

    rxr_desc_writer #(.BUF_BYTES(BUF)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_match(in_match), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .flag_clr(flag_clr), .frame_rcvd(frame_rcvd), .buf_unavail(buf_unavail)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [0:511];
    logic [63:0] expq [$];
    int  widx = 0;
    bit  hw_own [NDESC];
    bit  exp_frm, exp_bna;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with in-order write comparison (R1 R2 R3 R4 R5)
    always @(posedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                mem[mem_addr[10:2]] <= mem_wdata;
                if (expq.size() == 0) begin
                    chk(1'b0, "R5 unexpected write", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = expq.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R1/R2/R3/R4/R5 write", {mem_addr, mem_wdata}, e);
                end
            end else begin
                mem_rdata <= mem[mem_addr[10:2]];
            end
        end
    end

    function automatic logic [31:0] baddr(input int i);
        return BBASE + 32'(i * BUF);
    endfunction

    function automatic logic [31:0] w0(input int i);
        return baddr(i) | ((i == NDESC-1) ? 32'h2 : 32'h0);
    endfunction

    task automatic release_all();
        for (int i = 0; i < NDESC; i++) begin
            mem[(DBASE + 32'(8*i)) >> 2] = w0(i);
            hw_own[i] = 1'b0;
        end
    endtask

    task automatic plan_frame(input logic [7:0] fb[$], input logic [6:0] m);
        int n, pos, chunk;
        bit first, last;
        logic [31:0] word, st;
        n = fb.size(); pos = 0; first = 1'b1;
        exp_frm = 1'b0;
        while (pos < n) begin
            if (hw_own[widx]) begin exp_bna = 1'b1; return; end
            chunk = (n - pos < BUF) ? n - pos : BUF;
            for (int w = 0; w < (chunk + 3) / 4; w++) begin
                word = '0;
                for (int b = 0; b < 4; b++)
                    if (w*4 + b < chunk) word[8*b +: 8] = fb[pos + w*4 + b];
                expq.push_back({baddr(widx) + 32'(4*w), word});
            end
            last = (pos + chunk == n);
            st = {m[6], m[5], m[4], 2'b00, m[3:0], 7'b0, last, first, 2'b00,
                  last ? 12'(n) : 12'h000};
            expq.push_back({DBASE + 32'(8*widx) + 32'd4, st});
            expq.push_back({DBASE + 32'(8*widx), w0(widx) | 32'h1});
            hw_own[widx] = 1'b1;
            widx = (widx == NDESC-1) ? 0 : widx + 1;
            pos += chunk;
            first = 1'b0;
        end
        exp_frm = 1'b1;
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic push(input logic [7:0] d, input bit s, input bit e);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
    endtask

    task automatic send(input int n, input int seed, input logic [6:0] m, input bit model);
        logic [7:0] fb[$];
        for (int i = 0; i < n; i++) fb.push_back(8'(seed + 7*i));
        if (model) plan_frame(fb, m);
        in_match = m;
        for (int i = 0; i < n; i++) push(fb[i], i == 0, i == n-1);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R5 all expected writes seen", 64'(expq.size()), 64'd0);
    endtask

    task automatic clear_flags();
        flag_clr = 2'b11; @(negedge clk); flag_clr = 2'b00; @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        release_all();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_rcvd == 1'b0, "R8 reset frame_rcvd", 64'(frame_rcvd), 64'd0);
        chk(buf_unavail == 1'b0, "R8 reset buf_unavail", 64'(buf_unavail), 64'd0);
        chk(mem_req == 1'b0, "R9 no access while disabled", 64'(mem_req), 64'd0);
        repeat (2) @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);

        // short frame, R2 R3 R4
        send(10, 8'h11, 7'b1000101, 1'b1);
        chk(frame_rcvd == 1'b1, "R8 frame_rcvd set", 64'(frame_rcvd), 64'd1);
        clear_flags();
        chk(frame_rcvd == 1'b0, "R8 frame_rcvd cleared", 64'(frame_rcvd), 64'd0);
        release_all();

        // exact fit, R6
        send(BUF, 8'h40, 7'b0010000, 1'b1);
        chk(frame_rcvd == 1'b1, "R6 exact-fit frame done", 64'(frame_rcvd), 64'd1);
        clear_flags(); release_all();

        // spans buffers and wraps the ring, R1 R6
        send(37, 8'h80, 7'b0101010, 1'b1);
        chk(widx == 1, "R1 model wrapped", 64'(widx), 64'd1);
        chk(frame_rcvd == 1'b1, "R6 multi-buffer frame done", 64'(frame_rcvd), 64'd1);
        clear_flags(); release_all();

        // unreleased descriptor at the current position, R7
        mem[(DBASE + 32'(8*widx)) >> 2] = w0(widx) | 32'h1;
        hw_own[widx] = 1'b1;
        exp_bna = 1'b0;
        send(20, 8'h05, 7'b0000001, 1'b1);
        chk(buf_unavail == 1'b1, "R7 buf_unavail set", 64'(buf_unavail), 64'd1);
        chk(frame_rcvd == 1'b0, "R7 dropped frame not reported", 64'(frame_rcvd), 64'd0);
        clear_flags();
        chk(buf_unavail == 1'b0, "R8 buf_unavail cleared", 64'(buf_unavail), 64'd0);
        release_all();
        send(5, 8'h33, 7'b0000010, 1'b1);
        chk(frame_rcvd == 1'b1, "R7 same descriptor reused", 64'(frame_rcvd), 64'd1);
        clear_flags(); release_all();

        // frame cut off after its first buffer, R7
        hw_own[(widx + 1) % NDESC] = 1'b1;
        mem[(DBASE + 32'(8*((widx + 1) % NDESC))) >> 2] = w0((widx + 1) % NDESC) | 32'h1;
        send(30, 8'h21, 7'b1000000, 1'b1);
        chk(buf_unavail == 1'b1, "R7 partial frame cut", 64'(buf_unavail), 64'd1);
        chk(frame_rcvd == 1'b0, "R7 partial frame not reported", 64'(frame_rcvd), 64'd0);
        clear_flags(); release_all();

        // stray bytes while idle, R10
        in_match = 7'b0;
        push(8'hAA, 1'b0, 1'b0);
        push(8'hBB, 1'b0, 1'b1);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R10 stray bytes ignored", 64'(expq.size()), 64'd0);
        send(3, 8'h60, 7'b0001000, 1'b1);
        chk(frame_rcvd == 1'b1, "R10 next frame stored", 64'(frame_rcvd), 64'd1);
        clear_flags(); release_all();

        // disabled: bytes discarded, ring rewinds, R9
        rx_en = 1'b0;
        send(12, 8'h90, 7'b0, 1'b0);
        chk(frame_rcvd == 1'b0, "R9 disabled frame not stored", 64'(frame_rcvd), 64'd0);
        rx_en = 1'b1;
        widx = 0;
        @(negedge clk);
        send(1, 8'hC3, 7'b1111111, 1'b1);
        chk(frame_rcvd == 1'b1, "R9 rewound single-byte frame", 64'(frame_rcvd), 64'd1);
        clear_flags(); release_all();

        // whole ring in one frame, R1 R3
        send(60, 8'h07, 7'b0100100, 1'b1);
        chk(frame_rcvd == 1'b1, "R3 60-byte frame done", 64'(frame_rcvd), 64'd1);
        chk(buf_unavail == 1'b0, "R1 full ring no shortage", 64'(buf_unavail), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule